// File: doc/BRIEF.md
# Register-Remap Entry Stack Controller

This block keeps a small table of 16-bit remap entries packed as a stack. Slots 0 up to `fill-1` hold entries, and every slot above them reads as zero. The low five bits of an entry are its key. Commands come in through a valid/ready port and act on one of two ends. The "top" end is the highest occupied slot. The "bottom" end is always slot 0, and any insert or removal there moves every other entry by one slot.

There are two kinds of command:
- **Counted pop.** Removes up to N entries from the chosen end.
- **Data write.** An all-zero source pops a single entry. A non-zero source is taken apart 16 bits at a time, starting at the low end. Each piece either rewrites the entry that has the same key or is pushed at the chosen end. If the table is full, the push expels the entry at the opposite end.

Removed and expelled entries are packed into an XLEN-wide response, first one in bits 15:0, and returned through a valid/ready port. The whole table and its fill level are driven out continuously for the lookup logic.

Back-pressure works as follows:
- A command is taken only on a clock edge where `cmd_valid` and `cmd_ready` are both high.
- `cmd_ready` stays low from acceptance until the response has been taken.
- The response (`rsp_valid`, `rsp_data`) holds steady until `rsp_ready` is high on a clock edge.

Top module: `remap_stack`

## Requirements
- R1: After reset the fill level is 0, every entry is zero, `cmd_ready` is 1 and `rsp_valid` is 0. At all times, slots below the fill level hold non-zero entries and slots at or above it hold zero.
- R2: A counted pop on the top end (`cmd_bottom`=0) removes the highest entries one by one. The first removed goes to response bits 15:0 and the next one down to bits 31:16.
- R3: A counted pop on the bottom end (`cmd_bottom`=1) removes slot 0 repeatedly and moves the rest down. The first removed goes to bits 15:0, the next to bits 31:16.
- R4: A counted pop removes min(N, XLEN/16) entries when `cmd_dst_zero`=0. It removes exactly N entries (while any remain) when `cmd_dst_zero`=1, and only the first XLEN/16 of them are packed.
- R5: A data write whose source is all zero removes exactly one entry: the highest entry for the top end, or slot 0 with a shift down for the bottom end. That entry is returned in bits 15:0.
- R6: A non-zero source is handled as 16-bit pieces, starting with bits 15:0 and moving upward. Handling stops at the first all-zero piece or after XLEN/16 pieces.
- R7: A piece whose key (bits 4:0) equals the key of a present entry overwrites that entry in place. The fill level and all other slots stay unchanged.
- R8: A piece with no matching key is placed at slot `fill` on the top end. On the bottom end it is placed at slot 0, with all entries moved up one slot.
- R9: A push into a full table expels slot 0 (top end, with a shift down) or slot DEPTH-1 (bottom end). Expelled entries are packed in order from bits 15:0.
- R10: Response bits beyond the packed entries are zero. A pop on an empty table returns zero and leaves the table unchanged.
- R11: After acceptance, each following clock edge performs one entry operation, and `rsp_valid` rises on the edge after the last one. A command offered while `cmd_ready` is low has no effect.
- R12: `rsp_valid` and `rsp_data` hold while `rsp_ready` is low. The table does not change while a response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_bottom | input | 1 | 1 selects the bottom end, 0 the top end |
| cmd_popn | input | 1 | 1 selects a counted pop, 0 a data write |
| cmd_src | input | XLEN (64) | Source word for a data write |
| cmd_count | input | CNT_W (5) | Pop count N for a counted pop |
| cmd_dst_zero | input | 1 | Remove exactly N entries, ignoring the response width limit |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Response accepted |
| rsp_data | output | XLEN (64) | Packed removed or expelled entries |
| tbl_flat | output | DEPTH*16 (128) | Table contents, slot i at bits 16i+15:16i |
| tbl_fill | output | clog2(DEPTH+1) (4) | Number of occupied slots |

## Verification
Take a command accepted at edge E0 that performs k entry operations. The table outputs change at edges E1 through Ek, and `rsp_valid` is seen after edge Ek+1. A command that has nothing to do therefore answers after E1. The bench drives inputs on falling edges and steps a queue-based model on every rising edge. On each falling edge it compares the table, fill level, both ready/valid flags and any pending response against that model, so each result is checked in the exact cycle it is due. Directed commands additionally count falling edges from acceptance to `rsp_valid` against k+1. They also hold `rsp_ready` low for several cycles to confirm the response is held.

// File: rtl/remap_stack_pkg.sv
package remap_stack_pkg;
  localparam int ENTRY_W = 16;
  localparam int KEY_W   = 5;

  typedef enum logic [2:0] {
    ST_NOP,
    ST_SET,
    ST_PUSH_TOP,
    ST_POP_TOP,
    ST_PUSH_BOT,
    ST_POP_BOT
  } store_op_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RUN,
    PH_RESP
  } phase_e;
endpackage

// File: rtl/remap_stack_store.sv
module remap_stack_store
  import remap_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  store_op_e                  op,
  input  logic [ENTRY_W-1:0]         wdata,
  input  logic [IDX_W-1:0]           widx,
  output logic [DEPTH*ENTRY_W-1:0]   ent_flat,
  output logic [CW-1:0]              fill,
  output logic [ENTRY_W-1:0]         top_ent,
  output logic [ENTRY_W-1:0]         bot_ent,
  output logic [ENTRY_W-1:0]         last_ent,
  output logic                       full
);
  logic [ENTRY_W-1:0] ent [DEPTH];
  logic [ENTRY_W-1:0] nxt [DEPTH];
  logic               empty;

  assign full     = (fill == CW'(DEPTH));
  assign empty    = (fill == '0);
  assign top_ent  = empty ? '0 : ent[IDX_W'(fill - CW'(1))];
  assign bot_ent  = ent[0];
  assign last_ent = ent[DEPTH-1];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ENTRY_W-1:0] from_below; // value moving up into slot i
    logic [ENTRY_W-1:0] from_above; // value moving down into slot i
    logic [ENTRY_W-1:0] top_shift;  // slot i after a full top push
    logic [ENTRY_W-1:0] v;

    if (i == 0) begin : g_lo
      assign from_below = wdata;
    end else begin : g_mid
      assign from_below = ent[i-1];
    end

    if (i == DEPTH - 1) begin : g_hi
      assign from_above = '0;
      assign top_shift  = wdata;
    end else begin : g_nothi
      assign from_above = ent[i+1];
      assign top_shift  = ent[i+1];
    end

    always_comb begin
      v = ent[i];
      unique case (op)
        ST_SET:      if (widx == IDX_W'(i)) v = wdata;
        ST_PUSH_TOP: begin
          if (full) v = top_shift;
          else if (fill == CW'(i)) v = wdata;
        end
        ST_POP_TOP:  if (!empty && (fill - CW'(1)) == CW'(i)) v = '0;
        ST_PUSH_BOT: v = from_below;
        ST_POP_BOT:  v = from_above;
        default:     v = ent[i];
      endcase
    end

    assign nxt[i] = v;
    assign ent_flat[ENTRY_W*i +: ENTRY_W] = ent[i];

    // R1: occupied slots are non-zero, free slots are zero
    assert_compact_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (CW'(i) >= fill) |-> (ent[i] == '0));
    assert_compact_used_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (CW'(i) < fill) |-> (ent[i] != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) ent[k] <= '0;
      fill <= '0;
    end else begin
      ent <= nxt;
      unique case (op)
        ST_PUSH_TOP, ST_PUSH_BOT: if (!full)  fill <= fill + CW'(1);
        ST_POP_TOP,  ST_POP_BOT:  if (!empty) fill <= fill - CW'(1);
        default: ;
      endcase
    end
  end

  assert_fill_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  // R11: at most one entry operation per clock
  assert_one_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, fill} == {1'b0, $past(fill)}) ||
    ({1'b0, fill} == {1'b0, $past(fill)} + 1'b1) ||
    ({1'b0, fill} + 1'b1 == {1'b0, $past(fill)}));
endmodule

// File: rtl/remap_stack_match.sv
module remap_stack_match
  import remap_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH*ENTRY_W-1:0] ent_flat,
  input  logic [CW-1:0]            fill,
  input  logic [KEY_W-1:0]         key,
  output logic                     hit,
  output logic [IDX_W-1:0]         idx
);
  logic [DEPTH-1:0] eq;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign eq[i] = (CW'(i) < fill) &&
                   (ent_flat[ENTRY_W*i +: KEY_W] == key);
  end

  // lowest matching slot wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/remap_stack_pack.sv
module remap_stack_pack
  import remap_stack_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int SLOTS = XLEN / ENTRY_W,
  parameter int SW    = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               push,
  input  logic [ENTRY_W-1:0] din,
  output logic [XLEN-1:0]    result
);
  logic [ENTRY_W-1:0] slot_q [SLOTS];
  logic [SW-1:0]      used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used <= '0;
      for (int k = 0; k < SLOTS; k++) slot_q[k] <= '0;
    end else if (clear) begin
      used <= '0;
      for (int k = 0; k < SLOTS; k++) slot_q[k] <= '0;
    end else if (push && used != SW'(SLOTS)) begin
      slot_q[used[$clog2(SLOTS)-1:0]] <= din;
      used <= used + SW'(1);
    end
  end

  for (genvar j = 0; j < SLOTS; j++) begin : g_out
    assign result[ENTRY_W*j +: ENTRY_W] = slot_q[j];

    // R10: slots not yet filled read as zero
    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (SW'(j) >= used) |-> (slot_q[j] == '0));
  end
endmodule

// File: rtl/remap_stack.sv
module remap_stack
  import remap_stack_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int DEPTH = 8,
  parameter int CNT_W = 5,
  localparam int SLOTS = XLEN / ENTRY_W,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  output logic                     cmd_ready,
  input  logic                     cmd_bottom,
  input  logic                     cmd_popn,
  input  logic [XLEN-1:0]          cmd_src,
  input  logic [CNT_W-1:0]         cmd_count,
  input  logic                     cmd_dst_zero,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [XLEN-1:0]          rsp_data,
  output logic [DEPTH*ENTRY_W-1:0] tbl_flat,
  output logic [CW-1:0]            tbl_fill
);
  localparam logic [CNT_W-1:0] SLOTS_C = CNT_W'(SLOTS);

  phase_e             phase;
  logic               at_bot;
  logic               pop_mode;
  logic [CNT_W-1:0]   left;
  logic [XLEN-1:0]    src;

  store_op_e          op;
  logic [ENTRY_W-1:0] wdata;
  logic [IDX_W-1:0]   widx;
  logic [ENTRY_W-1:0] top_ent, bot_ent, last_ent;
  logic               full;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx;
  logic               pk_push;
  logic [ENTRY_W-1:0] pk_din;
  logic               finish;
  logic               accept;
  logic [ENTRY_W-1:0] chunk;

  assign cmd_ready = (phase == PH_IDLE);
  assign rsp_valid = (phase == PH_RESP);
  assign accept    = cmd_valid && cmd_ready;
  assign chunk     = src[ENTRY_W-1:0];

  remap_stack_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .wdata    (wdata),
    .widx     (widx),
    .ent_flat (tbl_flat),
    .fill     (tbl_fill),
    .top_ent  (top_ent),
    .bot_ent  (bot_ent),
    .last_ent (last_ent),
    .full     (full)
  );

  remap_stack_match #(.DEPTH(DEPTH)) u_match (
    .ent_flat (tbl_flat),
    .fill     (tbl_fill),
    .key      (chunk[KEY_W-1:0]),
    .hit      (hit),
    .idx      (hit_idx)
  );

  remap_stack_pack #(.XLEN(XLEN)) u_pack (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .push   (pk_push),
    .din    (pk_din),
    .result (rsp_data)
  );

  // one entry operation per RUN cycle
  always_comb begin
    op      = ST_NOP;
    wdata   = chunk;
    widx    = '0;
    pk_push = 1'b0;
    pk_din  = '0;
    finish  = 1'b0;
    if (phase == PH_RUN) begin
      if (pop_mode) begin
        if (left != '0 && tbl_fill != '0) begin
          op      = at_bot ? ST_POP_BOT : ST_POP_TOP;
          pk_push = 1'b1;
          pk_din  = at_bot ? bot_ent : top_ent;
        end else begin
          finish = 1'b1;
        end
      end else if (chunk != '0) begin
        if (hit) begin
          op   = ST_SET;
          widx = hit_idx;
        end else begin
          op = at_bot ? ST_PUSH_BOT : ST_PUSH_TOP;
          if (full) begin
            pk_push = 1'b1;
            pk_din  = at_bot ? last_ent : bot_ent;
          end
        end
      end else begin
        finish = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      at_bot   <= 1'b0;
      pop_mode <= 1'b0;
      left     <= '0;
      src      <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (accept) begin
          phase  <= PH_RUN;
          at_bot <= cmd_bottom;
          src    <= cmd_src;
          if (cmd_popn) begin
            pop_mode <= 1'b1;
            left     <= (cmd_dst_zero || cmd_count <= SLOTS_C) ? cmd_count : SLOTS_C;
          end else if (cmd_src == '0) begin
            pop_mode <= 1'b1;
            left     <= CNT_W'(1);
          end else begin
            pop_mode <= 1'b0;
            left     <= '0;
          end
        end
        PH_RUN: begin
          if (finish)        phase <= PH_RESP;
          else if (pop_mode) left  <= left - CNT_W'(1);
          else               src   <= src >> ENTRY_W;
        end
        PH_RESP: if (rsp_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R11: acceptance closes the command port
  assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R12: pending response holds
  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R12: no table change while a response is pending
  assert_rsp_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> ($stable(tbl_fill) && $stable(tbl_flat)));
endmodule

// File: tb/remap_stack_test.sv
module remap_stack_test;
  localparam int CLK_P = 10;
  localparam int XL    = 64;
  localparam int DEP   = 8;
  localparam int SL    = XL / 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cmd_valid = 1'b0;
  logic           cmd_ready;
  logic           cmd_bottom = 1'b0;
  logic           cmd_popn = 1'b0;
  logic [XL-1:0]  cmd_src = '0;
  logic [4:0]     cmd_count = '0;
  logic           cmd_dst_zero = 1'b0;
  logic           rsp_valid;
  logic           rsp_ready = 1'b0;
  logic [XL-1:0]  rsp_data;
  logic [DEP*16-1:0] tbl_flat;
  logic [3:0]     tbl_fill;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  remap_stack uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_bottom(cmd_bottom), .cmd_popn(cmd_popn), .cmd_src(cmd_src),
    .cmd_count(cmd_count), .cmd_dst_zero(cmd_dst_zero), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .tbl_flat(tbl_flat),
    .tbl_fill(tbl_fill)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] mq[$];
  int          mph = 0;          // 0 idle, 1 working, 2 answering
  bit          m_bot, m_popm;
  int          m_left;
  logic [XL-1:0] m_src;
  logic [15:0] mres [SL];
  int          mslot;

  task automatic put(input logic [15:0] e);
    if (mslot < SL) mres[mslot] = e;
    mslot++;
  endtask

  always @(posedge clk) begin
    logic [15:0] ch, e;
    int hit;
    if (!rst_n) begin
      mq.delete();
      mph = 0;
      mslot = 0;
      for (int k = 0; k < SL; k++) mres[k] = '0;
    end else begin
      case (mph)
        0: if (cmd_valid) begin
          mph = 1;
          m_bot = cmd_bottom;
          mslot = 0;
          for (int k = 0; k < SL; k++) mres[k] = '0;
          if (cmd_popn) begin
            m_popm = 1;
            m_left = cmd_dst_zero ? int'(cmd_count) :
                     (int'(cmd_count) > SL ? SL : int'(cmd_count));
          end else if (cmd_src == '0) begin
            m_popm = 1;
            m_left = 1;
          end else begin
            m_popm = 0;
            m_src = cmd_src;
          end
        end
        1: begin
          if (m_popm) begin
            if (m_left > 0 && mq.size() > 0) begin
              if (m_bot) e = mq.pop_front();
              else       e = mq.pop_back();
              put(e);
              m_left--;
            end else mph = 2;
          end else begin
            ch = m_src[15:0];
            if (ch != '0) begin
              hit = -1;
              for (int i = 0; i < mq.size(); i++)
                if (hit < 0 && mq[i][4:0] == ch[4:0]) hit = i;
              if (hit >= 0) mq[hit] = ch;
              else if (!m_bot) begin
                if (mq.size() == DEP) put(mq.pop_front());
                mq.push_back(ch);
              end else begin
                if (mq.size() == DEP) put(mq.pop_back());
                mq.push_front(ch);
              end
              m_src = m_src >> 16;
            end else mph = 2;
          end
        end
        default: if (rsp_ready) mph = 0;
      endcase
    end
  end

  // every-clock comparison, away from the rising edge
  always @(negedge clk) begin
    logic [DEP*16-1:0] ef;
    logic [XL-1:0] er;
    if (rst_n && !finished) begin
      ef = '0;
      for (int i = 0; i < DEP; i++) if (i < mq.size()) ef[16*i +: 16] = mq[i];
      for (int i = 0; i < SL; i++) er[16*i +: 16] = mres[i];
      chk(tbl_flat == ef, "R1 table contents", tbl_flat, ef);
      chk(int'(tbl_fill) == mq.size(), "R1 fill level", tbl_fill, mq.size());
      chk(cmd_ready == (mph == 0), "R11 cmd_ready", cmd_ready, mph == 0);
      chk(rsp_valid == (mph == 2), "R11 rsp_valid", rsp_valid, mph == 2);
      if (rsp_valid) chk(rsp_data == er, "R12 rsp_data", rsp_data, er);
    end
  end

  // issue one command and check its response; called at a falling edge
  task automatic run_cmd(input bit bot, input bit popn, input logic [XL-1:0] src,
                         input int cnt, input bit dz, input int hold,
                         input logic [XL-1:0] exp, input int exp_fill,
                         input int exp_lat, input bit inject, input string tag);
    int lat;
    while (!cmd_ready) @(negedge clk);
    cmd_bottom = bot; cmd_popn = popn; cmd_src = src;
    cmd_count = 5'(cnt); cmd_dst_zero = dz; cmd_valid = 1'b1;
    @(negedge clk);
    if (inject) begin
      cmd_bottom = 1'b1; cmd_popn = 1'b1; cmd_count = 5'd5; cmd_dst_zero = 1'b1;
    end else cmd_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      lat++;
    end
    cmd_valid = 1'b0;
    chk(rsp_data == exp, {tag, " response"}, rsp_data, exp);
    if (exp_lat >= 0) chk(lat == exp_lat, "R11 response latency", lat, exp_lat);
    for (int h = 0; h < hold; h++) @(negedge clk);
    chk(rsp_valid && rsp_data == exp, "R12 held response", rsp_data, exp);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(int'(tbl_fill) == exp_fill, {tag, " fill"}, tbl_fill, exp_fill);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tbl_fill == 0 && tbl_flat == '0, "R1 reset table", tbl_fill, 0);
    chk(cmd_ready && !rsp_valid, "R1 reset handshake", {cmd_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 / R8 top appends, pieces low first
    run_cmd(0, 0, 64'h0000_A003_A002_A001, 0, 0, 0, 64'h0, 3, 4, 0, "R8");
    chk(tbl_flat[47:0] == 48'hA003_A002_A001, "R8 top order", tbl_flat[47:0], 48'hA003_A002_A001);
    run_cmd(0, 0, 64'h0000_A009_0000_A004, 0, 0, 0, 64'h0, 4, 2, 0, "R6");
    // R8 bottom inserts
    run_cmd(1, 0, 64'h0000_0000_B006_B005, 0, 0, 2, 64'h0, 6, 3, 0, "R8");
    chk(tbl_flat[15:0] == 16'hB006, "R8 bottom slot0", tbl_flat[15:0], 16'hB006);
    // R7 key update
    run_cmd(0, 0, 64'h0000_0000_0000_C002, 0, 0, 0, 64'h0, 6, 2, 0, "R7");
    chk(tbl_flat[63:48] == 16'hC002, "R7 in-place update", tbl_flat[63:48], 16'hC002);
    // R9 overflow at both ends
    run_cmd(0, 0, 64'hC00A_C009_C008_C007, 0, 0, 1, 64'h0000_0000_B005_B006, 8, 5, 0, "R9");
    run_cmd(1, 0, 64'h0000_0000_0000_D00B, 0, 0, 0, 64'h0000_0000_0000_C00A, 8, 2, 0, "R9");
    chk(tbl_flat[15:0] == 16'hD00B, "R9 bottom slot0", tbl_flat[15:0], 16'hD00B);
    // R2 / R3 counted pops
    run_cmd(0, 1, 64'h0, 3, 0, 0, 64'h0000_C007_C008_C009, 5, 4, 0, "R2");
    run_cmd(1, 1, 64'h0, 2, 0, 0, 64'h0000_0000_A001_D00B, 3, 3, 0, "R3");
    // R4 width limit and exact removal
    run_cmd(0, 0, 64'hE00F_E00E_E00D_E00C, 0, 0, 0, 64'h0, 7, 5, 0, "R8");
    run_cmd(0, 1, 64'h0, 6, 0, 0, 64'hE00C_E00D_E00E_E00F, 3, 5, 0, "R4");
    run_cmd(0, 0, 64'hE00F_E00E_E00D_E00C, 0, 0, 0, 64'h0, 7, 5, 0, "R8");
    run_cmd(1, 1, 64'h0, 6, 1, 0, 64'hE00C_A004_A003_C002, 1, 7, 0, "R4");
    chk(tbl_flat[15:0] == 16'hE00F, "R4 remaining entry", tbl_flat[15:0], 16'hE00F);
    // R5 zero-source pops
    run_cmd(0, 0, 64'h0000_0000_F011_F010, 0, 0, 0, 64'h0, 3, 3, 0, "R8");
    run_cmd(0, 0, 64'h0, 0, 0, 0, 64'h0000_0000_0000_F011, 2, 2, 0, "R5");
    run_cmd(1, 0, 64'h0, 0, 0, 0, 64'h0000_0000_0000_E00F, 1, 2, 0, "R5");
    chk(tbl_flat[15:0] == 16'hF010, "R5 shifted down", tbl_flat[15:0], 16'hF010);
    // R10 empty pops
    run_cmd(0, 1, 64'h0, 3, 0, 0, 64'h0000_0000_0000_F010, 0, 2, 0, "R10");
    run_cmd(1, 1, 64'h0, 2, 0, 0, 64'h0, 0, 1, 0, "R10");
    run_cmd(0, 0, 64'h0, 0, 0, 0, 64'h0, 0, 1, 0, "R10");
    run_cmd(0, 1, 64'h0, 0, 1, 0, 64'h0, 0, 1, 0, "R10");
    // R11 command offered while busy is ignored; R12 long hold
    run_cmd(0, 0, 64'h0000_1023_1022_1021, 0, 0, 4, 64'h0, 3, 4, 1, "R11");
    chk(tbl_flat[47:0] == 48'h1023_1022_1021, "R11 busy command ignored",
        tbl_flat[47:0], 48'h1023_1022_1021);
    // R6 full width of pieces, all pushed, none expelled
    run_cmd(1, 0, 64'h2034_2033_2032_2031, 0, 0, 0, 64'h0, 7, 5, 0, "R6");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule